// File: doc/BRIEF.md
# Filter configuration load port

This block receives one channel's configuration stream for an image filter: a 12-bit word bus plus a load strobe that marks the word as an address. It decodes the address to choose a storage target, collects the data words that follow on later clocks, and writes the whole group into the target in a single cycle once the last word has arrived. A second filter channel uses its own instance with its own strobe and bus.

Targets are coefficient sets (eight 12-bit taps each), a configuration register, a select register, round registers (48 bits) and limit registers (a 16-bit lower and a 16-bit upper bound). A pause input freezes collection for as many clocks as it is held. The block has no back-pressure. It takes a word on every clock that pause leaves free. The pause input is the source's only way to stall it. Stored values can be read back at any time through combinational read ports.

Top module: `cfg_load_port`

## Requirements
- R1: Address words decode as follows: 0x000–0x0FF select coefficient set 0–255, 0x100 the configuration register, 0x101 the select register, 0x110–0x12F round register 0–31, 0x130–0x14F limit register 0–31; any other value is unmapped.
- R2: A coefficient load is an address word plus eight data words, data word k becoming tap k. The set is written on the edge that ends the clock after the eighth word, so read-back shows it two edges after that word.
- R3: The configuration and select registers each take one data word and show the new value right after the edge that samples that word.
- R4: A round load takes four data words and stores {w3,w2,w1,w0} (48 bits, w0 least significant), visible right after the edge that samples w3.
- R5: A limit load takes four data words; the lower bound is {w1[7:0],w0[7:0]} and the upper bound is {w3[7:0],w2[7:0]}, visible right after the edge that samples w3.
- R6: No storage changes before the last data word of a transaction has been received.
- R7: On a clock with pause high the bus word and the load strobe are both ignored and collection state holds; the final write is delayed by the number of paused clocks.
- R8: A load strobe in the middle of a transaction abandons the partial words without any write and starts a new transaction with the current word as its address.
- R9: An unmapped address starts no transaction: the words after it are not collected and nothing is written.
- R10: Words without a load strobe while no transaction is open are ignored.
- R11: After reset every stored value reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_strobe | input | 1 | Marks the current bus word as an address |
| pause | input | 1 | Freezes collection; bus word ignored |
| cfg_word | input | 12 | Configuration bus word |
| rd_coef_set | input | 8 | Coefficient set to read back |
| rd_coef_tap | input | 3 | Tap within that set |
| rd_coef | output | 12 | Selected coefficient |
| cfg_value | output | 12 | Configuration register |
| sel_value | output | 12 | Select register |
| rd_round_idx | input | 5 | Round register to read back |
| rd_round | output | 48 | Selected round register |
| rd_limit_idx | input | 5 | Limit register to read back |
| rd_limit_lo | output | 16 | Lower bound of selected limit |
| rd_limit_hi | output | 16 | Upper bound of selected limit |

## Verification
On every cycle the assertions check that a paused clock leaves the word counter, open target and busy flag unchanged, that no write leaves while idle, on an abandoning strobe, or after an unmapped address, that the counter stays below the target's word count, and that the configuration register only moves after its commit. Only the bench's scenarios show that the assembled values land in the right place with the right packing, that the coefficient write comes one clock later than the register writes, and that abandoned groups leave their target untouched.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
  typedef enum logic [2:0] {
    T_NONE  = 3'd0,
    T_COEF  = 3'd1,
    T_CFG   = 3'd2,
    T_SEL   = 3'd3,
    T_ROUND = 3'd4,
    T_LIMIT = 3'd5
  } tgt_e;
endpackage

// File: rtl/cfgl_decode.sv
module cfgl_decode import cfgl_pkg::*; #(
  parameter int W = 12,
  parameter int IDX_W = 8,
  parameter int COEF_SETS = 256,
  parameter int ROUND_REGS = 32,
  parameter int LIMIT_REGS = 32,
  parameter logic [W-1:0] CFG_ADDR = 12'h100,
  parameter logic [W-1:0] SEL_ADDR = 12'h101,
  parameter logic [W-1:0] ROUND_BASE = 12'h110,
  parameter logic [W-1:0] LIMIT_BASE = 12'h130
) (
  input  logic [W-1:0]     addr,
  output tgt_e             tgt,
  output logic [IDX_W-1:0] idx
);
  localparam logic [W-1:0] COEF_END  = W'(COEF_SETS);
  localparam logic [W-1:0] ROUND_END = ROUND_BASE + W'(ROUND_REGS);
  localparam logic [W-1:0] LIMIT_END = LIMIT_BASE + W'(LIMIT_REGS);

  always_comb begin
    tgt = T_NONE;
    idx = '0;
    if (addr < COEF_END) begin
      tgt = T_COEF;
      idx = IDX_W'(addr);
    end else if (addr == CFG_ADDR) begin
      tgt = T_CFG;
    end else if (addr == SEL_ADDR) begin
      tgt = T_SEL;
    end else if (addr >= ROUND_BASE && addr < ROUND_END) begin
      tgt = T_ROUND;
      idx = IDX_W'(addr - ROUND_BASE);
    end else if (addr >= LIMIT_BASE && addr < LIMIT_END) begin
      tgt = T_LIMIT;
      idx = IDX_W'(addr - LIMIT_BASE);
    end
  end
endmodule

// File: rtl/cfgl_collect.sv
module cfgl_collect import cfgl_pkg::*; #(
  parameter int W = 12,
  parameter int TAPS = 8,
  parameter int GROUP_WORDS = 4,
  parameter int IDX_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld,
  input  logic                     pause,
  input  logic [W-1:0]             word,
  input  tgt_e                     dec_tgt,
  input  logic [IDX_W-1:0]         dec_idx,
  output tgt_e                     wr_tgt,
  output logic [IDX_W-1:0]         wr_idx,
  output logic [TAPS-1:0][W-1:0]   wr_words
);
  localparam int CW = $clog2(TAPS) + 1;

  logic                   busy;
  tgt_e                   tgt_q;
  logic [IDX_W-1:0]       idx_q;
  logic [CW-1:0]          cnt;
  logic [TAPS-1:0][W-1:0] held;
  logic [CW-1:0]          need;
  logic                   last;

  function automatic logic [CW-1:0] words_for(tgt_e t);
    case (t)
      T_COEF:          return CW'(TAPS);
      T_CFG, T_SEL:    return CW'(1);
      T_ROUND, T_LIMIT: return CW'(GROUP_WORDS);
      default:         return '0;
    endcase
  endfunction

  always_comb begin
    need = words_for(tgt_q);
    last = busy && !pause && !ld && (cnt == need - CW'(1));
    for (int i = 0; i < TAPS; i++)
      wr_words[i] = (CW'(i) == cnt) ? word : held[i];
    wr_tgt = last ? tgt_q : T_NONE;
    wr_idx = idx_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      tgt_q <= T_NONE;
      idx_q <= '0;
      cnt   <= '0;
      held  <= '0;
    end else if (pause) begin
      // stalled clock: everything holds
    end else if (ld) begin
      busy  <= (dec_tgt != T_NONE);
      tgt_q <= dec_tgt;
      idx_q <= dec_idx;
      cnt   <= '0;
    end else if (busy) begin
      for (int i = 0; i < TAPS; i++)
        if (CW'(i) == cnt) held[i] <= word;
      if (last) busy <= 1'b0;
      else      cnt  <= cnt + CW'(1);
    end
  end

  assert_pause_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pause |=> $stable(cnt) && $stable(busy) && $stable(tgt_q));

  assert_abort_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ld) |-> wr_tgt == T_NONE);

  assert_unmapped_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && !pause && dec_tgt == T_NONE) |=> wr_tgt == T_NONE);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> wr_tgt == T_NONE);

  assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < need);
endmodule

// File: rtl/cfgl_store.sv
module cfgl_store import cfgl_pkg::*; #(
  parameter int W = 12,
  parameter int TAPS = 8,
  parameter int GROUP_WORDS = 4,
  parameter int IDX_W = 8,
  parameter int COEF_SETS = 256,
  parameter int ROUND_REGS = 32,
  parameter int LIMIT_REGS = 32,
  parameter int LIM_BYTE = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  tgt_e                           wr_tgt,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [TAPS-1:0][W-1:0]         wr_words,
  input  logic [$clog2(COEF_SETS)-1:0]   rd_coef_set,
  input  logic [$clog2(TAPS)-1:0]        rd_coef_tap,
  output logic [W-1:0]                   rd_coef,
  output logic [W-1:0]                   cfg_value,
  output logic [W-1:0]                   sel_value,
  input  logic [$clog2(ROUND_REGS)-1:0]  rd_round_idx,
  output logic [GROUP_WORDS*W-1:0]       rd_round,
  input  logic [$clog2(LIMIT_REGS)-1:0]  rd_limit_idx,
  output logic [2*LIM_BYTE-1:0]          rd_limit_lo,
  output logic [2*LIM_BYTE-1:0]          rd_limit_hi
);
  localparam int RAW = $clog2(ROUND_REGS);
  localparam int LAW = $clog2(LIMIT_REGS);
  localparam int BW  = 2 * LIM_BYTE;

  logic [TAPS-1:0][W-1:0]   coef_mem  [COEF_SETS];
  logic [GROUP_WORDS*W-1:0] round_mem [ROUND_REGS];
  logic [2*BW-1:0]          limit_mem [LIMIT_REGS];
  logic [W-1:0]             cfg_q, sel_q;
  logic                     coef_pend;
  logic [IDX_W-1:0]         pend_idx;
  logic [TAPS-1:0][W-1:0]   pend_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < COEF_SETS; s++) coef_mem[s] <= '0;
      for (int r = 0; r < ROUND_REGS; r++) round_mem[r] <= '0;
      for (int l = 0; l < LIMIT_REGS; l++) limit_mem[l] <= '0;
      cfg_q     <= '0;
      sel_q     <= '0;
      coef_pend <= 1'b0;
      pend_idx  <= '0;
      pend_data <= '0;
    end else begin
      if (coef_pend) coef_mem[pend_idx] <= pend_data;
      coef_pend <= (wr_tgt == T_COEF);
      if (wr_tgt == T_COEF) begin
        pend_idx  <= wr_idx;
        pend_data <= wr_words;
      end
      case (wr_tgt)
        T_CFG:   cfg_q <= wr_words[0];
        T_SEL:   sel_q <= wr_words[0];
        T_ROUND: round_mem[wr_idx[RAW-1:0]] <= wr_words[GROUP_WORDS-1:0];
        T_LIMIT: limit_mem[wr_idx[LAW-1:0]] <=
                   {wr_words[3][LIM_BYTE-1:0], wr_words[2][LIM_BYTE-1:0],
                    wr_words[1][LIM_BYTE-1:0], wr_words[0][LIM_BYTE-1:0]};
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_coef     = coef_mem[rd_coef_set][rd_coef_tap];
    cfg_value   = cfg_q;
    sel_value   = sel_q;
    rd_round    = round_mem[rd_round_idx];
    rd_limit_lo = limit_mem[rd_limit_idx][BW-1:0];
    rd_limit_hi = limit_mem[rd_limit_idx][2*BW-1:BW];
  end

  assert_cfg_after_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_q) |-> $past(wr_tgt) == T_CFG);

  assert_coef_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tgt == T_COEF) |-> !coef_pend);
endmodule

// File: rtl/cfg_load_port.sv
module cfg_load_port import cfgl_pkg::*; #(
  parameter int W = 12,
  parameter int TAPS = 8,
  parameter int GROUP_WORDS = 4,
  parameter int COEF_SETS = 256,
  parameter int ROUND_REGS = 32,
  parameter int LIMIT_REGS = 32,
  parameter int LIM_BYTE = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          load_strobe,
  input  logic                          pause,
  input  logic [W-1:0]                  cfg_word,
  input  logic [$clog2(COEF_SETS)-1:0]  rd_coef_set,
  input  logic [$clog2(TAPS)-1:0]       rd_coef_tap,
  output logic [W-1:0]                  rd_coef,
  output logic [W-1:0]                  cfg_value,
  output logic [W-1:0]                  sel_value,
  input  logic [$clog2(ROUND_REGS)-1:0] rd_round_idx,
  output logic [GROUP_WORDS*W-1:0]      rd_round,
  input  logic [$clog2(LIMIT_REGS)-1:0] rd_limit_idx,
  output logic [2*LIM_BYTE-1:0]         rd_limit_lo,
  output logic [2*LIM_BYTE-1:0]         rd_limit_hi
);
  localparam int SET_AW = $clog2(COEF_SETS);
  localparam int RND_AW = $clog2(ROUND_REGS);
  localparam int LIM_AW = $clog2(LIMIT_REGS);
  localparam int MAX_RL = (RND_AW > LIM_AW) ? RND_AW : LIM_AW;
  localparam int IDX_W  = (SET_AW > MAX_RL) ? SET_AW : MAX_RL;

  tgt_e                   dec_tgt, wr_tgt;
  logic [IDX_W-1:0]       dec_idx, wr_idx;
  logic [TAPS-1:0][W-1:0] wr_words;

  cfgl_decode #(.W(W), .IDX_W(IDX_W), .COEF_SETS(COEF_SETS),
                .ROUND_REGS(ROUND_REGS), .LIMIT_REGS(LIMIT_REGS)) u_dec (
    .addr(cfg_word), .tgt(dec_tgt), .idx(dec_idx));

  cfgl_collect #(.W(W), .TAPS(TAPS), .GROUP_WORDS(GROUP_WORDS), .IDX_W(IDX_W)) u_col (
    .clk(clk), .rst_n(rst_n), .ld(load_strobe), .pause(pause), .word(cfg_word),
    .dec_tgt(dec_tgt), .dec_idx(dec_idx),
    .wr_tgt(wr_tgt), .wr_idx(wr_idx), .wr_words(wr_words));

  cfgl_store #(.W(W), .TAPS(TAPS), .GROUP_WORDS(GROUP_WORDS), .IDX_W(IDX_W),
               .COEF_SETS(COEF_SETS), .ROUND_REGS(ROUND_REGS),
               .LIMIT_REGS(LIMIT_REGS), .LIM_BYTE(LIM_BYTE)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_tgt(wr_tgt), .wr_idx(wr_idx), .wr_words(wr_words),
    .rd_coef_set(rd_coef_set), .rd_coef_tap(rd_coef_tap), .rd_coef(rd_coef),
    .cfg_value(cfg_value), .sel_value(sel_value),
    .rd_round_idx(rd_round_idx), .rd_round(rd_round),
    .rd_limit_idx(rd_limit_idx), .rd_limit_lo(rd_limit_lo), .rd_limit_hi(rd_limit_hi));
endmodule

// File: tb/cfg_load_port_test.sv
`timescale 1ns/1ps
module cfg_load_port_test;
  typedef logic [11:0] wv_t [8];

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld = 1'b0, pz = 1'b0;
  logic [11:0] word = '0;
  logic [7:0]  rd_set = '0;
  logic [2:0]  rd_tap = '0;
  logic [4:0]  rd_ridx = '0, rd_lidx = '0;
  logic [11:0] rd_coef, cfg_value, sel_value;
  logic [47:0] rd_round;
  logic [15:0] rd_lo, rd_hi;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  logic [11:0] m_coef [256][8];
  logic [47:0] m_round [32];
  logic [15:0] m_lo [32], m_hi [32];
  logic [11:0] m_cfg, m_sel;

  always #2 clk = ~clk;

  cfg_load_port uut (
    .clk(clk), .rst_n(rst_n), .load_strobe(ld), .pause(pz), .cfg_word(word),
    .rd_coef_set(rd_set), .rd_coef_tap(rd_tap), .rd_coef(rd_coef),
    .cfg_value(cfg_value), .sel_value(sel_value),
    .rd_round_idx(rd_ridx), .rd_round(rd_round),
    .rd_limit_idx(rd_lidx), .rd_limit_lo(rd_lo), .rd_limit_hi(rd_hi));

  // kinds: 0 coef, 1 cfg, 2 sel, 3 round, 4 limit
  function automatic logic [11:0] addr_of(int kind, int idx);
    case (kind)
      0: return 12'(idx);
      1: return 12'h100;
      2: return 12'h101;
      3: return 12'(12'h110 + idx);
      default: return 12'(12'h130 + idx);
    endcase
  endfunction

  function automatic int words_of(int kind);
    return (kind == 0) ? 8 : (kind <= 2) ? 1 : 4;
  endfunction

  function automatic logic [47:0] pack_round(wv_t w);
    return {w[3], w[2], w[1], w[0]};
  endfunction
  function automatic logic [15:0] pack_lo(wv_t w);
    return {w[1][7:0], w[0][7:0]};
  endfunction
  function automatic logic [15:0] pack_hi(wv_t w);
    return {w[3][7:0], w[2][7:0]};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic l, input logic p, input logic [11:0] w);
    @(negedge clk);
    ld = l; pz = p; word = w;
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 12'($urandom));
  endtask

  task automatic apply(input int kind, input int idx, input wv_t w);
    case (kind)
      0: for (int k = 0; k < 8; k++) m_coef[idx][k] = w[k];
      1: m_cfg = w[0];
      2: m_sel = w[0];
      3: m_round[idx] = pack_round(w);
      default: begin m_lo[idx] = pack_lo(w); m_hi[idx] = pack_hi(w); end
    endcase
  endtask

  task automatic check_kind(input int kind, input int idx, input string tag);
    case (kind)
      0: for (int k = 0; k < 8; k++) begin
           rd_set = 8'(idx); rd_tap = 3'(k); #1;
           check(tag, 64'(rd_coef), 64'(m_coef[idx][k]));
         end
      1: begin #1; check(tag, 64'(cfg_value), 64'(m_cfg)); end
      2: begin #1; check(tag, 64'(sel_value), 64'(m_sel)); end
      3: begin rd_ridx = 5'(idx); #1; check(tag, 64'(rd_round), 64'(m_round[idx])); end
      default: begin
        rd_lidx = 5'(idx); #1;
        check(tag, 64'(rd_lo), 64'(m_lo[idx]));
        check(tag, 64'(rd_hi), 64'(m_hi[idx]));
      end
    endcase
  endtask

  // address then n_send data words, with random paused clocks (ld random on them)
  task automatic send(input int kind, input int idx, input int n_send,
                      input wv_t w, input int pause_pct);
    drive(1'b1, 1'b0, addr_of(kind, idx));
    for (int k = 0; k < n_send; k++) begin
      while (int'($urandom_range(99)) < pause_pct)
        drive(1'($urandom_range(1)), 1'b1, 12'($urandom));
      drive(1'b0, 1'b0, w[k]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R7 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    wv_t w;
    void'($urandom(32'd20240611));
    for (int s = 0; s < 256; s++) for (int k = 0; k < 8; k++) m_coef[s][k] = '0;
    for (int r = 0; r < 32; r++) begin m_round[r] = '0; m_lo[r] = '0; m_hi[r] = '0; end
    m_cfg = '0; m_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset contents
    check_kind(1, 0, "R11 cfg reset");
    check_kind(2, 0, "R11 sel reset");
    check_kind(0, 255, "R11 coef reset");
    check_kind(3, 31, "R11 round reset");
    check_kind(4, 0, "R11 limit reset");

    // R3 timing: value present right after the edge sampling the data word
    drive(1'b1, 1'b0, 12'h100);
    drive(1'b0, 1'b0, 12'hABC);
    #1 check("R6 cfg before last edge", 64'(cfg_value), 64'h0);
    idle();
    #1 check("R3 cfg after data edge", 64'(cfg_value), 64'hABC);
    m_cfg = 12'hABC;

    // R2 timing: coefficient set 5 lands one clock later
    for (int k = 0; k < 8; k++) w[k] = 12'(12'h300 + k * 17);
    send(0, 5, 8, w, 0);
    idle();
    rd_set = 8'd5; rd_tap = 3'd7; #1;
    check("R2 coef not yet written", 64'(rd_coef), 64'h0);
    idle();
    apply(0, 5, w);
    check_kind(0, 5, "R2 coef set written");

    // R7: pause with strobe and a cfg address on the bus is ignored
    for (int k = 0; k < 4; k++) w[k] = 12'(12'h5A0 + k);
    drive(1'b1, 1'b0, 12'h112);
    drive(1'b0, 1'b0, w[0]);
    drive(1'b1, 1'b1, 12'h100);
    drive(1'b1, 1'b1, 12'h100);
    drive(1'b0, 1'b0, w[1]);
    drive(1'b0, 1'b0, w[2]);
    #1 check("R7 round not early", 64'(rd_round), 64'h0);
    drive(1'b0, 1'b0, w[3]);
    idle();
    apply(3, 2, w);
    check_kind(3, 2, "R4 R7 round after paused load");
    check_kind(1, 0, "R7 cfg untouched by paused strobe");

    // R8: abandon a limit load with a select load
    for (int k = 0; k < 4; k++) w[k] = 12'hFFF;
    send(4, 3, 2, w, 0);
    w[0] = 12'h077;
    send(2, 0, 1, w, 0);
    idle();
    m_sel = 12'h077;
    check_kind(4, 3, "R8 abandoned limit unchanged");
    check_kind(2, 0, "R8 select from new transaction");

    // R9: unmapped address followed by cfg-looking words
    drive(1'b1, 1'b0, 12'h102);
    drive(1'b0, 1'b0, 12'h100);
    drive(1'b0, 1'b0, 12'h123);
    idle(); idle();
    check_kind(1, 0, "R9 cfg after unmapped");
    check_kind(2, 0, "R9 sel after unmapped");

    // R10: idle words without strobe
    drive(1'b0, 1'b0, 12'h101);
    drive(1'b0, 1'b0, 12'h055);
    idle();
    check_kind(2, 0, "R10 sel after idle words");

    // R5 directed packing
    w[0] = 12'hA34; w[1] = 12'hB12; w[2] = 12'hC78; w[3] = 12'hD56;
    send(4, 31, 4, w, 0);
    idle();
    rd_lidx = 5'd31; #1;
    check("R5 limit lower", 64'(rd_lo), 64'h1234);
    check("R5 limit upper", 64'(rd_hi), 64'h5678);
    apply(4, 31, w);

    // random mix (R1 decode across the map)
    begin
      bit ab_pend = 0;
      int ab_kind = 0, ab_idx = 0;
      for (int t = 0; t < 400; t++) begin
        int kind, idx, n, pct;
        kind = int'($urandom_range(5));
        pct = int'($urandom_range(30));
        for (int k = 0; k < 8; k++) w[k] = 12'($urandom);
        if (kind == 5) begin
          logic [11:0] ua;
          ua = $urandom_range(1) ? 12'(12'h102 + $urandom_range(13))
                                 : 12'(12'h150 + $urandom_range(12'hEAF));
          drive(1'b1, 1'b0, ua);
          for (int k = 0; k < 4; k++) drive(1'b0, 1'b0, k[0] ? 12'h100 : 12'h101);
          idle();
          check_kind(1, 0, "R9 random unmapped cfg");
          check_kind(2, 0, "R9 random unmapped sel");
        end else begin
          idx = (kind == 0) ? int'($urandom_range(255)) :
                (kind >= 3) ? int'($urandom_range(31)) : 0;
          n = words_of(kind);
          if (n > 1 && $urandom_range(7) == 0) begin
            send(kind, idx, int'($urandom_range(n - 1)), w, pct);
            ab_pend = 1; ab_kind = kind; ab_idx = idx;
            continue;
          end
          send(kind, idx, n, w, pct);
          idle(); idle();
          apply(kind, idx, w);
          case (kind)
            0: check_kind(0, idx, "R1 R2 random coef");
            1: check_kind(1, 0, "R1 R3 random cfg");
            2: check_kind(2, 0, "R1 R3 random sel");
            3: check_kind(3, idx, "R1 R4 random round");
            default: check_kind(4, idx, "R1 R5 random limit");
          endcase
        end
        if (ab_pend) begin
          check_kind(ab_kind, ab_idx, "R8 random abandoned target");
          ab_pend = 0;
        end
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule